// File: doc/BRIEF.md
# Multi-Task Consensus Watchdog

This block supervises a set of periodic software tasks. Each task has its own input and raises it for one cycle when it finishes a pass of its work. The block keeps one alive flag per task. A down-counter runs from a preset value toward zero, and it is reloaded only when every flag is set. No single task can keep the watchdog quiet on behalf of the others, and the tasks never measure time themselves. Every judgement about timeliness is made inside this block.

When the counter reaches zero while at least one flag is still clear, the block reacts in one of two ways, chosen by a configuration input:
- it drives a fixed-length system reset pulse and starts a fresh window, or
- it latches a halt output that holds until a maintenance clear input releases it.

Every timeout is recorded in two ways. A saturating event counter counts the timeouts. A bitmask records which tasks were missing at the most recent timeout. The preset is a design-time parameter and should be set only slightly above the period of the slowest task. The reset input is asynchronous and active low, and it is expected to be released synchronously to `clk`.

Top module: `task_consensus_wdog`

## Requirements
- R1: While reset is asserted, and directly after it is released, `sys_rst_o` and `halt_o` are low and `miss_mask_o` and `evt_cnt_o` are zero. The counter starts at `TIMEOUT_CYC`.
- R2: A one-cycle high on `task_done_i[i]` sets the alive flag of task i. The flag stays set until the next window restart, whatever happens on that input in the meantime.
- R3: When all flags are set at a clock edge, the counter reloads to `TIMEOUT_CYC` at that edge and no timeout occurs. A window that started at edge P, with some flag still clear, times out at edge P+TIMEOUT_CYC+1.
- R4: At a window restart, either a reload or a reset-mode timeout, all flags are cleared. A completion pulse sampled at that same edge sets its flag again for the new window.
- R5: At a timeout, `miss_mask_o` captures a mask in which bit i is 1 when task i had not reported. Bit 0 belongs to task 0. The mask holds until the next timeout or until `maint_clr_i` is sampled high.
- R6: With `react_halt_i` = 0 at the timeout edge, `sys_rst_o` is high for exactly `RST_PULSE_CYC` cycles, starting directly after that edge. The next window starts at that same edge.
- R7: With `react_halt_i` = 1 at the timeout edge, `halt_o` rises and stays high. While it is high, the counter, the event count and `sys_rst_o` do not change. All flags stay clear and completion pulses are ignored.
- R8: A high `maint_clr_i` sampled at an edge clears `halt_o` and `miss_mask_o` and starts a new window with all flags clear. No timeout can occur at that edge.
- R9: `evt_cnt_o` rises by one at each timeout and saturates at its all-ones value. It does not wrap.
- R10: A flag that becomes set at the edge where the counter reaches zero still earns a reload at the following edge, so no timeout occurs. A completion sampled at the timeout edge itself is counted as missing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| task_done_i | input | NUM_TASKS | One-cycle completion pulse per task |
| react_halt_i | input | 1 | Reaction select: 0 gives a reset pulse, 1 gives a latched halt |
| maint_clr_i | input | 1 | Maintenance clear for the halt latch and the missing-task mask |
| sys_rst_o | output | 1 | System reset pulse |
| halt_o | output | 1 | Latched permanent shutdown |
| miss_mask_o | output | NUM_TASKS | Tasks missing at the latest timeout |
| evt_cnt_o | output | EVT_W | Saturating count of timeout events |

## Verification
The bound checker checks the following on every cycle:
- a unanimous vote reloads the counter;
- an expired count with a silent task produces a reaction;
- the flags stay sticky inside a window;
- the reset pulse has exactly the programmed length;
- the halt latch holds and freezes the counter and the event count;
- a clear empties the record;
- the event count moves by at most one and sticks at its maximum.

Other behaviours can only be shown by the bench's scenarios, which predict the exact cycle of each timeout:
- the edge at which a timeout lands;
- the just-in-time and one-cycle-late boundaries;
- a pulse that arrives in the restart cycle carrying into the next window;
- pulses given during a halt leaving no trace after the clear;
- the value of each captured mask.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  // Reaction taken when a window expires with at least one silent task
  typedef enum logic {
    REACT_RESET = 1'b0,
    REACT_HALT  = 1'b1
  } react_e;

endpackage

// File: rtl/tcw_alive_flags.sv
module tcw_alive_flags #(
  parameter int NUM_TASKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TASKS-1:0] done_i,
  input  logic                 restart_i,
  input  logic                 flush_i,
  output logic [NUM_TASKS-1:0] alive_o
);

  // One sticky flag per task.
  // flush_i wins over restart_i, and restart_i wins over accumulation.
  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_d = flag_q | done_i[i];
      if (flush_i) begin
        flag_d = 1'b0;
      end else if (restart_i) begin
        flag_d = done_i[i];
      end
    end

    assign flag_en = flush_i | restart_i | done_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_en) begin
        flag_q <= flag_d;
      end
    end

    assign alive_o[i] = flag_q;
  end

endmodule

// File: rtl/tcw_countdown.sv
module tcw_countdown #(
  parameter int PRESET = 1000,
  localparam int CNT_W = $clog2(PRESET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  localparam logic [CNT_W-1:0] PRESET_V = CNT_W'(PRESET);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = PRESET_V;
    end else if (!hold_i && !at_zero) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = load_i | (!hold_i & !at_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= PRESET_V;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = at_zero;

endmodule

// File: rtl/tcw_reaction.sv
module tcw_reaction
  import tcw_pkg::*;
#(
  parameter int PULSE_CYC = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire_i,
  input  react_e mode_i,
  input  logic   clear_i,
  output logic   sys_rst_o,
  output logic   halt_o
);

  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PULSE_V = PW'(PULSE_CYC);

  logic [PW-1:0] pulse_q;
  logic [PW-1:0] pulse_d;
  logic          pulse_en;
  logic          halt_q;
  logic          halt_d;
  logic          halt_en;
  logic          fire_rst;
  logic          fire_halt;

  assign fire_rst  = fire_i & (mode_i == REACT_RESET);
  assign fire_halt = fire_i & (mode_i == REACT_HALT);

  // Reset pulse length counter
  always_comb begin
    pulse_d = pulse_q;
    if (fire_rst) begin
      pulse_d = PULSE_V;
    end else if (pulse_q != '0) begin
      pulse_d = pulse_q - 1'b1;
    end
  end

  assign pulse_en = fire_rst | (pulse_q != '0);

  // Halt latch: only the maintenance clear releases it
  always_comb begin
    halt_d = halt_q;
    if (clear_i) begin
      halt_d = 1'b0;
    end else if (fire_halt) begin
      halt_d = 1'b1;
    end
  end

  assign halt_en = clear_i | fire_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else if (pulse_en) begin
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (halt_en) begin
      halt_q <= halt_d;
    end
  end

  assign sys_rst_o = (pulse_q != '0);
  assign halt_o    = halt_q;

endmodule

// File: rtl/tcw_event_log.sv
module tcw_event_log #(
  parameter int NUM_TASKS = 4,
  parameter int EVT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire_i,
  input  logic [NUM_TASKS-1:0] missing_i,
  input  logic                 clear_i,
  output logic [NUM_TASKS-1:0] mask_o,
  output logic [EVT_W-1:0]     count_o
);

  localparam logic [EVT_W-1:0] EVT_MAX = '1;

  logic [NUM_TASKS-1:0] mask_q;
  logic [NUM_TASKS-1:0] mask_d;
  logic                 mask_en;
  logic [EVT_W-1:0]     cnt_q;
  logic [EVT_W-1:0]     cnt_d;
  logic                 cnt_en;

  always_comb begin
    mask_d = mask_q;
    if (clear_i) begin
      mask_d = '0;
    end else if (fire_i) begin
      mask_d = missing_i;
    end
  end

  assign mask_en = clear_i | fire_i;

  assign cnt_d  = cnt_q + 1'b1;
  assign cnt_en = fire_i & (cnt_q != EVT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign mask_o  = mask_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/task_consensus_wdog.sv
module task_consensus_wdog
  import tcw_pkg::*;
#(
  parameter int NUM_TASKS     = 4,
  parameter int TIMEOUT_CYC   = 1000,
  parameter int RST_PULSE_CYC = 8,
  parameter int EVT_W         = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TASKS-1:0] task_done_i,
  input  logic                 react_halt_i,
  input  logic                 maint_clr_i,
  output logic                 sys_rst_o,
  output logic                 halt_o,
  output logic [NUM_TASKS-1:0] miss_mask_o,
  output logic [EVT_W-1:0]     evt_cnt_o
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [NUM_TASKS-1:0] alive_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 cnt_zero;
  logic                 all_alive;
  logic                 active;
  logic                 reload_w;
  logic                 timeout_w;
  logic                 restart_w;
  logic                 flush_w;
  react_e               mode_w;

  // Window control: a unanimous vote reloads; an expired count with a
  // silent task fires. Both are suppressed while halted or being cleared.
  assign all_alive = &alive_q;
  assign active    = !halt_o && !maint_clr_i;
  assign reload_w  = active && all_alive;
  assign timeout_w = active && !all_alive && cnt_zero;
  assign restart_w = reload_w | timeout_w;
  assign flush_w   = maint_clr_i | halt_o;
  assign mode_w    = react_halt_i ? REACT_HALT : REACT_RESET;

  tcw_alive_flags #(
    .NUM_TASKS (NUM_TASKS)
  ) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (task_done_i),
    .restart_i (restart_w),
    .flush_i   (flush_w),
    .alive_o   (alive_q)
  );

  tcw_countdown #(
    .PRESET (TIMEOUT_CYC)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (restart_w | maint_clr_i),
    .hold_i (halt_o),
    .cnt_o  (cnt_q),
    .zero_o (cnt_zero)
  );

  tcw_reaction #(
    .PULSE_CYC (RST_PULSE_CYC)
  ) u_react (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (timeout_w),
    .mode_i    (mode_w),
    .clear_i   (maint_clr_i),
    .sys_rst_o (sys_rst_o),
    .halt_o    (halt_o)
  );

  tcw_event_log #(
    .NUM_TASKS (NUM_TASKS),
    .EVT_W     (EVT_W)
  ) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (timeout_w),
    .missing_i (~alive_q),
    .clear_i   (maint_clr_i),
    .mask_o    (miss_mask_o),
    .count_o   (evt_cnt_o)
  );

endmodule

// File: rtl/tcw_checker.sv
module tcw_checker #(
  parameter int NUM_TASKS     = 4,
  parameter int TIMEOUT_CYC   = 1000,
  parameter int RST_PULSE_CYC = 8,
  parameter int EVT_W         = 8,
  localparam int CNT_W        = $clog2(TIMEOUT_CYC + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_TASKS-1:0] task_done_i,
  input logic                 maint_clr_i,
  input logic [NUM_TASKS-1:0] alive_q,
  input logic [CNT_W-1:0]     cnt_q,
  input logic                 timeout_w,
  input logic                 sys_rst_o,
  input logic                 halt_o,
  input logic [NUM_TASKS-1:0] miss_mask_o,
  input logic [EVT_W-1:0]     evt_cnt_o
);

  localparam logic [CNT_W-1:0] PRESET_V = CNT_W'(TIMEOUT_CYC);
  localparam logic [EVT_W-1:0] EVT_MAX  = '1;

  // Length of the current reset pulse, counted here and not in the design
  int run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else begin
      run_q <= sys_rst_o ? run_q + 1 : 0;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PRESET_V);

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&alive_q && !halt_o && !maint_clr_i) |=> (cnt_q == PRESET_V));

  p_timeout_reacts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !(&alive_q) && !halt_o && !maint_clr_i) |=> (sys_rst_o || halt_o));

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&alive_q) && cnt_q != '0 && !halt_o && !maint_clr_i)
      |=> ((alive_q & ($past(alive_q) | $past(task_done_i))) == ($past(alive_q) | $past(task_done_i))));

  p_mask_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> (miss_mask_o == ~$past(alive_q)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeout_w && !maint_clr_i) |=> $stable(miss_mask_o));

  p_pulse_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RST_PULSE_CYC);

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (run_q == RST_PULSE_CYC));

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !maint_clr_i) |=> (halt_o && $stable(cnt_q) && $stable(evt_cnt_o) && alive_q == '0));

  p_no_rst_in_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !$rose(sys_rst_o));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    maint_clr_i |=> (!halt_o && miss_mask_o == '0 && alive_q == '0));

  p_evt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_cnt_o == $past(evt_cnt_o) || evt_cnt_o == $past(evt_cnt_o) + 1'b1));

  p_evt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cnt_o == EVT_MAX) |=> (evt_cnt_o == EVT_MAX));

endmodule

bind task_consensus_wdog tcw_checker #(
  .NUM_TASKS     (NUM_TASKS),
  .TIMEOUT_CYC   (TIMEOUT_CYC),
  .RST_PULSE_CYC (RST_PULSE_CYC),
  .EVT_W         (EVT_W)
) u_tcw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .task_done_i (task_done_i),
  .maint_clr_i (maint_clr_i),
  .alive_q     (alive_q),
  .cnt_q       (cnt_q),
  .timeout_w   (timeout_w),
  .sys_rst_o   (sys_rst_o),
  .halt_o      (halt_o),
  .miss_mask_o (miss_mask_o),
  .evt_cnt_o   (evt_cnt_o)
);

// File: tb/sim_task_consensus_wdog.sv
module sim_task_consensus_wdog;

  localparam int N  = 4;
  localparam int T  = 20;
  localparam int PW = 3;
  localparam int EW = 3;
  localparam int EVT_SAT = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  td = '0;
  logic          mode = 1'b0;
  logic          clr = 1'b0;
  logic          sys_rst;
  logic          halt;
  logic [N-1:0]  mask;
  logic [EW-1:0] evt;

  task_consensus_wdog #(
    .NUM_TASKS     (N),
    .TIMEOUT_CYC   (T),
    .RST_PULSE_CYC (PW),
    .EVT_W         (EW)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_done_i  (td),
    .react_halt_i (mode),
    .maint_clr_i  (clr),
    .sys_rst_o    (sys_rst),
    .halt_o       (halt),
    .miss_mask_o  (mask),
    .evt_cnt_o    (evt)
  );

  always #5 clk = ~clk;

  // Edge counter: after edge k since reset release, cyc == k
  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int compared = 0;
  int mismatched = 0;
  bit done_flag = 1'b0;

  typedef struct {
    int           at;
    logic [N-1:0] m;
    bit           h;
    int           ev;
  } exp_t;

  exp_t expq[$];
  exp_t got;
  int   n_evt = 0;
  int   win = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: predict a timeout for the current window and restart it there
  task automatic expect_timeout(input logic [N-1:0] m, input bit h, output int e);
    exp_t x;
    e = win + T + 1;
    n_evt++;
    x.at = e;
    x.m  = m;
    x.h  = h;
    x.ev = (n_evt > EVT_SAT) ? EVT_SAT : n_evt;
    expq.push_back(x);
    win = e;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m, output int s);
    @(negedge clk);
    td = m;
    s = cyc + 1;
    @(negedge clk);
    td = '0;
  endtask

  task automatic pulse2(input logic [N-1:0] a, input logic [N-1:0] b, output int s);
    @(negedge clk);
    td = a;
    s = cyc + 1;
    @(negedge clk);
    td = b;
    @(negedge clk);
    td = '0;
  endtask

  // Monitor: every rising reaction is matched against the queue
  logic prev_r = 1'b0;
  logic prev_h = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((sys_rst && !prev_r) || (halt && !prev_h)) begin
        if (expq.size() == 0) begin
          compared++;
          mismatched++;
          $display("FAIL R3: unpredicted timeout, actual cycle %0d expected none", cyc);
        end else begin
          got = expq.pop_front();
          check("R3 timeout edge", cyc, got.at);
          check("R5 missing mask", mask, got.m);
          check("R7 halt reaction", halt, got.h);
          check("R6 reset reaction", sys_rst, !got.h);
          check("R9 event count", evt, got.ev);
        end
      end
      prev_r = sys_rst;
      prev_h = halt;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int s;
    int e;
    int c;
    repeat (3) @(negedge clk);
    check("R1 sys_rst in reset", sys_rst, 0);
    check("R1 halt in reset", halt, 0);
    check("R1 mask in reset", mask, 0);
    check("R1 evt in reset", evt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sys_rst after release", sys_rst, 0);
    check("R1 evt after release", evt, 0);
    win = 0;

    // R2/R3: staggered reports from all tasks keep the watchdog quiet
    for (int k = 0; k < 3; k++) begin
      wait_cyc(win + 4);
      for (int i = 0; i < N; i++) begin
        pulse(N'(1) << i, s);
      end
      win = s + 1;
    end
    check("R2 staggered flags reload", evt, 0);
    check("R3 no reset on unanimous vote", sys_rst, 0);

    // R10: last flag set at the edge the counter reaches zero
    wait_cyc(win + 2);
    pulse(4'b0111, s);
    wait_cyc(win + T - 2);
    pulse(4'b1000, s);
    check("R10 last report edge", s, win + T);
    win = s + 1;
    wait_cyc(win + 3);
    check("R10 just-in-time reload", evt, 0);

    // R5/R6/R10: task 2 reports on the timeout edge itself
    wait_cyc(win + 2);
    pulse(4'b1011, s);
    expect_timeout(4'b0100, 1'b0, e);
    wait_cyc(e - 2);
    pulse(4'b0100, s);
    check("R10 late report edge", s, e);
    check("R6 pulse cycle 1", sys_rst, 1);
    @(negedge clk);
    check("R6 pulse cycle 2", sys_rst, 1);
    @(negedge clk);
    check("R6 pulse cycle 3", sys_rst, 1);
    @(negedge clk);
    check("R6 pulse ends", sys_rst, 0);
    // Task 2 was kept from the restart edge, so the others suffice (R4)
    pulse(4'b1011, s);
    win = s + 1;
    wait_cyc(win + 2);
    check("R5 mask held", mask, 4'b0100);
    check("R4 carry at timeout restart", evt, 1);

    // R4: pulse in the reload cycle counts for the next window
    wait_cyc(win + 2);
    pulse(4'b0111, s);
    wait_cyc(win + 8);
    pulse2(4'b1000, 4'b0010, s);
    win = s + 1;
    wait_cyc(win + 2);
    pulse(4'b1101, s);
    win = s + 1;
    wait_cyc(win + 2);
    check("R4 carry at reload", evt, 1);

    // R7: halt mode latches, freezes and ignores reports
    @(negedge clk);
    mode = 1'b1;
    wait_cyc(win + 2);
    pulse(4'b0011, s);
    expect_timeout(4'b1100, 1'b1, e);
    wait_cyc(e);
    check("R7 halt set", halt, 1);
    check("R7 no reset pulse", sys_rst, 0);
    for (int k = 0; k < 5; k++) begin
      pulse(4'b1111, s);
    end
    wait_cyc(e + 60);
    check("R7 halt holds", halt, 1);
    check("R7 evt frozen", evt, 2);
    check("R7 mask frozen", mask, 4'b1100);
    check("R7 no reset while halted", sys_rst, 0);

    // R8: maintenance clear
    @(negedge clk);
    clr = 1'b1;
    c = cyc + 1;
    @(negedge clk);
    clr = 1'b0;
    mode = 1'b0;
    check("R8 halt cleared", halt, 0);
    check("R8 mask cleared", mask, 0);
    win = c;
    expect_timeout(4'b1111, 1'b0, e);
    wait_cyc(e + 4);
    check("R7 halted reports discarded", mask, 4'b1111);

    // R9: saturation of the event count
    for (int k = 0; k < 6; k++) begin
      expect_timeout(4'b1111, 1'b0, e);
    end
    wait_cyc(e + 4);
    check("R9 saturated", evt, EVT_SAT);

    check("R3 all predicted timeouts seen", expq.size(), 0);
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule